// File: doc/BRIEF.md
# Overlay-Aware System Address Decoder

This block sits between a 16-bit-data, 24-bit-address processor bus and the system's memories and peripherals. It turns each bus cycle (word address, read/write, upper and lower byte strobes, write data) into RAM read or per-lane write enables, a ROM read, or one of several peripheral chip selects: an interface adapter, a floppy controller, and a serial controller that has separate read and write windows. It also builds the returned read word from the RAM, ROM and 8-bit peripheral data paths.

A boot overlay flag, set by reset, moves ROM to the bottom of the read map so the processor can fetch its reset vectors. Software clears it later through bit 4 of the adapter's port A output. The flag changes only where reads go. Writes below the peripheral region always land in RAM. Peripheral windows are matched on sparse address patterns rather than ranges. The block also produces a one-cycle enable for the slow adapter, which it derives by dividing the processor clock.

Top module: `sys_addr_decoder`

## Requirements
- R1: With the overlay clear, a strobed read at byte address below 0x400000 selects RAM and one in 0x400000..0x7FFFFF selects ROM. ram_addr is cpu_addr[RAM_AW:1] and rom_addr is cpu_addr[ROM_AW:1], so both sizes wrap. The read word is the selected memory's data.
- R2: With the overlay set, strobed reads in 0x000000..0x5FFFFF select ROM and those in 0x600000..0x7FFFFF select RAM.
- R3: A strobed write below 0x800000 goes to RAM whatever the overlay. ram_we_hi (data bits 15:8) follows the upper strobe and ram_we_lo (bits 7:0) follows the lower strobe, so a single-byte write leaves the other lane untouched. ram_wdata carries cpu_wdata. No write ever selects ROM, and no peripheral-space write enables RAM.
- R4: slow_bus is high exactly when byte address bit 23 is set (0x800000 and above).
- R5: The adapter is selected when byte address bits 23:13 equal 0x77F and bits 8:1 are all ones. dev_reg is then address bits 12:9 and via_we marks a write. A read returns {0xFF, via_rdata}.
- R6: The floppy controller is selected when bits 23:13 equal 0x6FF and bits 8:1 are all ones. dev_reg is bits 12:9 and fdc_we marks a write. A read returns {0xFF, fdc_rdata}.
- R7: scc_rd_cs is asserted for reads in 0x9FFFF8..0x9FFFFF and scc_wr_cs for writes in 0xBFFFF8..0xBFFFFF. dev_reg is {2'b00, address bits 2:1}. A read returns {0xFF, scc_rdata}.
- R8: The read word is 0xFFFF for an unmatched peripheral read, for any write, and when no strobe is active. A cycle with no strobe asserts no select or write enable.
- R9: After reset the overlay is set. A clock edge with adapter_pa_load high loads adapter_pa4 into it (1 = overlay on). With adapter_pa_load low, the overlay holds its value.
- R10: slow_en is a one-cycle pulse every SLOW_HALF/2 clocks (5 with the default of 10 half-periods). It is low during reset and first rises after the fourth clock edge following reset release.
- R11: At most one of ram_rd, rom_rd, via_cs, fdc_cs, scc_rd_cs and scc_wr_cs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 23 | Word address, byte address bits 23:1 |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_uds | input | 1 | Upper byte strobe, active high |
| cpu_lds | input | 1 | Lower byte strobe, active high |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data returned to the processor |
| slow_bus | output | 1 | Peripheral-space (synchronous slow bus) access |
| ram_addr | output | RAM_AW | RAM word address |
| ram_rd | output | 1 | RAM read select |
| ram_we_hi | output | 1 | RAM upper lane write enable |
| ram_we_lo | output | 1 | RAM lower lane write enable |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data |
| rom_addr | output | ROM_AW | ROM word address |
| rom_rd | output | 1 | ROM read select |
| rom_rdata | input | 16 | ROM read data |
| dev_reg | output | 4 | Peripheral register index |
| dev_wdata | output | 8 | Peripheral write data (low byte) |
| via_cs | output | 1 | Interface adapter select |
| via_we | output | 1 | Interface adapter write |
| via_rdata | input | 8 | Interface adapter read data |
| fdc_cs | output | 1 | Floppy controller select |
| fdc_we | output | 1 | Floppy controller write |
| fdc_rdata | input | 8 | Floppy controller read data |
| scc_rd_cs | output | 1 | Serial controller read window select |
| scc_wr_cs | output | 1 | Serial controller write window select |
| scc_rdata | input | 8 | Serial controller read data |
| adapter_pa4 | input | 1 | Adapter port A bit 4 output level |
| adapter_pa_load | input | 1 | Adapter port A output was written this cycle |
| slow_en | output | 1 | Divided enable for the slow adapter |

## Verification
The properties assume that reset is held low from time zero through at least one clock edge. They also assume that adapter_pa4 is valid on any edge where adapter_pa_load is high. The bench meets both by driving reset low before the first edge and by changing the load inputs only at falling edges. The decode properties are pure functions of the current cycle and assume nothing about the sequence of bus cycles. The bench therefore sweeps every top address byte against a set of low-order patterns, for both directions, all four strobe combinations and both overlay states. The patterns are chosen to land exactly on, and just beside, every sparse peripheral pattern.

// File: rtl/sad_pkg.sv
// Shared types and decode constants for the system address decoder.
// Assumes byte address bit 0 is not presented (word bus with byte strobes).
package sad_pkg;
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_RAM,
        SRC_ROM,
        SRC_ADP,
        SRC_FLP,
        SRC_SER
    } rd_src_t;

    localparam logic [10:0] ADP_HI  = 11'h77F;     // byte address bits 23:13
    localparam logic [10:0] FLP_HI  = 11'h6FF;     // byte address bits 23:13
    localparam logic [7:0]  DEV_LO  = 8'hFF;       // byte address bits 8:1
    localparam logic [20:0] SER_RD  = 21'h13FFFF;  // byte address bits 23:3
    localparam logic [20:0] SER_WR  = 21'h17FFFF;  // byte address bits 23:3
    localparam logic [15:0] IDLE_RD = 16'hFFFF;
endpackage

// File: rtl/sad_region.sv
// Region decoder: classifies one bus cycle into RAM, ROM or a peripheral
// select and produces the write enables and register index.
// Assumes strobes are only asserted while the address is valid.
module sad_region
    import sad_pkg::*;
(
    input  logic [23:1] addr,
    input  logic        rd,
    input  logic        uds,
    input  logic        lds,
    input  logic        overlay,
    output rd_src_t     src,
    output logic        ram_rd,
    output logic        rom_rd,
    output logic        ram_we_hi,
    output logic        ram_we_lo,
    output logic        via_cs,
    output logic        via_we,
    output logic        fdc_cs,
    output logic        fdc_we,
    output logic        scc_rd_cs,
    output logic        scc_wr_cs,
    output logic        slow_bus,
    output logic [3:0]  dev_reg
);
    logic active, periph, mem_rd, mem_wr, ram_win;
    logic adp_hit, flp_hit, ser_r_hit, ser_w_hit;

    // Address-space classification for the current cycle.
    always_comb begin
        active    = uds | lds;
        periph    = addr[23];
        ram_win   = overlay ? (addr[22:21] == 2'b11) : ~addr[22];
        mem_rd    = active & rd & ~periph;
        mem_wr    = active & ~rd & ~periph;
        adp_hit   = active & periph & (addr[23:13] == ADP_HI) & (addr[8:1] == DEV_LO);
        flp_hit   = active & periph & (addr[23:13] == FLP_HI) & (addr[8:1] == DEV_LO);
        ser_r_hit = active & rd & (addr[23:3] == SER_RD);
        ser_w_hit = active & ~rd & (addr[23:3] == SER_WR);
    end

    // Select, enable and read-source outputs.
    always_comb begin
        slow_bus  = periph;
        ram_rd    = mem_rd & ram_win;
        rom_rd    = mem_rd & ~ram_win;
        ram_we_hi = mem_wr & uds;
        ram_we_lo = mem_wr & lds;
        via_cs    = adp_hit;
        via_we    = adp_hit & ~rd;
        fdc_cs    = flp_hit;
        fdc_we    = flp_hit & ~rd;
        scc_rd_cs = ser_r_hit;
        scc_wr_cs = ser_w_hit;
        dev_reg   = (ser_r_hit | ser_w_hit) ? {2'b00, addr[2:1]} : addr[12:9];
        if (!(active && rd))    src = SRC_NONE;
        else if (ram_rd)        src = SRC_RAM;
        else if (rom_rd)        src = SRC_ROM;
        else if (adp_hit)       src = SRC_ADP;
        else if (flp_hit)       src = SRC_FLP;
        else if (ser_r_hit)     src = SRC_SER;
        else                    src = SRC_NONE;
    end
endmodule

// File: rtl/sad_rdmux.sv
// Read-data steering: forms the returned word from one source.
// 8-bit peripherals sit on the low lane; the high lane reads as all ones.
module sad_rdmux
    import sad_pkg::*;
(
    input  rd_src_t     src,
    input  logic [15:0] ram_rdata,
    input  logic [15:0] rom_rdata,
    input  logic [7:0]  via_rdata,
    input  logic [7:0]  fdc_rdata,
    input  logic [7:0]  scc_rdata,
    output logic [15:0] rdata
);
    // One-hot source to data word.
    always_comb begin
        unique case (src)
            SRC_RAM: rdata = ram_rdata;
            SRC_ROM: rdata = rom_rdata;
            SRC_ADP: rdata = {8'hFF, via_rdata};
            SRC_FLP: rdata = {8'hFF, fdc_rdata};
            SRC_SER: rdata = {8'hFF, scc_rdata};
            default: rdata = IDLE_RD;
        endcase
    end
endmodule

// File: rtl/sad_slow_en.sv
// Slow peripheral enable: a one-cycle pulse every SLOW_HALF/2 clocks.
// Assumes SLOW_HALF is even and at least 2.
module sad_slow_en #(
    parameter int SLOW_HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic en
);
    localparam int DIV = SLOW_HALF / 2;
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt;
            // Divider counter, wraps at DIV-1.
            always_ff @(posedge clk) begin
                if (!rst_n)                        cnt <= '0;
                else if (cnt == CW'(DIV - 1))      cnt <= '0;
                else                               cnt <= cnt + 1'b1;
            end
            // Pulse on the last count of each period.
            always_comb en = rst_n & (cnt == CW'(DIV - 1));

            assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
                en |=> !en);
        end else begin : g_pass
            // Divide by one: enable every cycle out of reset.
            always_comb en = rst_n;
        end
    endgenerate
endmodule

// File: rtl/sys_addr_decoder.sv
// System address decoder top: holds the boot overlay flag, decodes each
// bus cycle and steers read data. Memories and peripherals are external
// and assumed to answer combinationally in the same cycle.
module sys_addr_decoder
    import sad_pkg::*;
#(
    parameter int RAM_AW    = 16,
    parameter int ROM_AW    = 15,
    parameter int SLOW_HALF = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [23:1]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_uds,
    input  logic              cpu_lds,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    output logic              slow_bus,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_we_hi,
    output logic              ram_we_lo,
    output logic [15:0]       ram_wdata,
    input  logic [15:0]       ram_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_rd,
    input  logic [15:0]       rom_rdata,
    output logic [3:0]        dev_reg,
    output logic [7:0]        dev_wdata,
    output logic              via_cs,
    output logic              via_we,
    input  logic [7:0]        via_rdata,
    output logic              fdc_cs,
    output logic              fdc_we,
    input  logic [7:0]        fdc_rdata,
    output logic              scc_rd_cs,
    output logic              scc_wr_cs,
    input  logic [7:0]        scc_rdata,
    input  logic              adapter_pa4,
    input  logic              adapter_pa_load,
    output logic              slow_en
);
    logic    overlay_q;
    rd_src_t src;

    // Boot overlay flag: set by reset, loaded from adapter port A bit 4.
    always_ff @(posedge clk) begin
        if (!rst_n)               overlay_q <= 1'b1;
        else if (adapter_pa_load) overlay_q <= adapter_pa4;
    end

    // Memory addresses wrap by truncation; write data passes straight through.
    always_comb begin
        ram_addr  = cpu_addr[RAM_AW:1];
        rom_addr  = cpu_addr[ROM_AW:1];
        ram_wdata = cpu_wdata;
        dev_wdata = cpu_wdata[7:0];
    end

    sad_region u_region (
        .addr      (cpu_addr),
        .rd        (cpu_rd),
        .uds       (cpu_uds),
        .lds       (cpu_lds),
        .overlay   (overlay_q),
        .src       (src),
        .ram_rd    (ram_rd),
        .rom_rd    (rom_rd),
        .ram_we_hi (ram_we_hi),
        .ram_we_lo (ram_we_lo),
        .via_cs    (via_cs),
        .via_we    (via_we),
        .fdc_cs    (fdc_cs),
        .fdc_we    (fdc_we),
        .scc_rd_cs (scc_rd_cs),
        .scc_wr_cs (scc_wr_cs),
        .slow_bus  (slow_bus),
        .dev_reg   (dev_reg)
    );

    sad_rdmux u_rdmux (
        .src       (src),
        .ram_rdata (ram_rdata),
        .rom_rdata (rom_rdata),
        .via_rdata (via_rdata),
        .fdc_rdata (fdc_rdata),
        .scc_rdata (scc_rdata),
        .rdata     (cpu_rdata)
    );

    sad_slow_en #(.SLOW_HALF(SLOW_HALF)) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (slow_en)
    );

    assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_rd, rom_rd, via_cs, fdc_cs, scc_rd_cs, scc_wr_cs}));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_uds || cpu_lds) |->
        !(ram_rd || rom_rd || ram_we_hi || ram_we_lo || via_cs || fdc_cs || scc_rd_cs || scc_wr_cs));

    assert_rom_never_written_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> !rom_rd);

    assert_periph_no_ram_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[23] |-> !(ram_we_hi || ram_we_lo));

    assert_adapter_high_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (via_cs && cpu_rd) |-> (cpu_rdata[15:8] == 8'hFF));

    assert_overlay_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adapter_pa_load |=> (overlay_q == $past(adapter_pa4)));
endmodule

// File: tb/sys_addr_decoder_test.sv
`timescale 1ns/1ps
module sys_addr_decoder_test;
    localparam int RAM_AW = 16;
    localparam int ROM_AW = 15;
    localparam int PERIOD = 5;   // 10 half-periods

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [23:0] a = '0;
    logic rd = 1'b1, uds = 1'b0, lds = 1'b0;
    logic [15:0] wdata = '0;
    logic pa4 = 1'b0, pa_load = 1'b0;

    logic [15:0] cpu_rdata, ram_wdata, ram_rdata, rom_rdata;
    logic [RAM_AW-1:0] ram_addr;
    logic [ROM_AW-1:0] rom_addr;
    logic slow_bus, ram_rd, ram_we_hi, ram_we_lo, rom_rd;
    logic [3:0] dev_reg;
    logic [7:0] dev_wdata;
    logic via_cs, via_we, fdc_cs, fdc_we, scc_rd_cs, scc_wr_cs, slow_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Memory models answer combinationally from the address.
    assign ram_rdata = ~ram_addr;
    assign rom_rdata = {1'b1, rom_addr} ^ 16'h0F0F;

    sys_addr_decoder #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW), .SLOW_HALF(10)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(a[23:1]), .cpu_rd(rd),
        .cpu_uds(uds), .cpu_lds(lds), .cpu_wdata(wdata), .cpu_rdata(cpu_rdata),
        .slow_bus(slow_bus), .ram_addr(ram_addr), .ram_rd(ram_rd),
        .ram_we_hi(ram_we_hi), .ram_we_lo(ram_we_lo), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .rom_addr(rom_addr), .rom_rd(rom_rd),
        .rom_rdata(rom_rdata), .dev_reg(dev_reg), .dev_wdata(dev_wdata),
        .via_cs(via_cs), .via_we(via_we), .via_rdata(8'h3C),
        .fdc_cs(fdc_cs), .fdc_we(fdc_we), .fdc_rdata(8'h96),
        .scc_rd_cs(scc_rd_cs), .scc_wr_cs(scc_wr_cs), .scc_rdata(8'h5A),
        .adapter_pa4(pa4), .adapter_pa_load(pa_load), .slow_en(slow_en)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp, input logic [23:0] ad);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s addr=%06h got=%0h exp=%0h", req, ad, got, exp);
        end
    endtask

    // One bus cycle: drive, settle, compare against the arithmetic model.
    task automatic access(input logic [23:0] ad, input logic r, input logic u, input logic l, input logic ov);
        logic act, per, ramwin, e_ramrd, e_romrd, e_whi, e_wlo, e_via, e_fdc, e_sr, e_sw, devsel;
        logic [15:0] e_rd;
        string tag;
        a = ad; rd = r; uds = u; lds = l; wdata = ad[15:0] ^ 16'h1357;
        #1;
        act     = u | l;
        per     = ad[23];
        ramwin  = ov ? (ad[22:21] == 2'b11) : ~ad[22];
        e_ramrd = act & r & ~per & ramwin;
        e_romrd = act & r & ~per & ~ramwin;
        e_whi   = act & ~r & ~per & u;
        e_wlo   = act & ~r & ~per & l;
        e_via   = act & per & (ad[23:13] == 11'h77F) & (ad[8:1] == 8'hFF);
        e_fdc   = act & per & (ad[23:13] == 11'h6FF) & (ad[8:1] == 8'hFF);
        e_sr    = act & r & (ad[23:3] == 21'h13FFFF);
        e_sw    = act & ~r & (ad[23:3] == 21'h17FFFF);
        devsel  = e_via | e_fdc | e_sr | e_sw;
        if (!(act && r))  e_rd = 16'hFFFF;
        else if (e_ramrd) e_rd = ~ad[16:1];
        else if (e_romrd) e_rd = {1'b1, ad[15:1]} ^ 16'h0F0F;
        else if (e_via)   e_rd = 16'hFF3C;
        else if (e_fdc)   e_rd = 16'hFF96;
        else if (e_sr)    e_rd = 16'hFF5A;
        else              e_rd = 16'hFFFF;
        if (per)       tag = e_via ? "R5" : e_fdc ? "R6" : (e_sr | e_sw) ? "R7" : "R8";
        else if (!act) tag = "R8";
        else if (!r)   tag = "R3";
        else           tag = ov ? "R2" : "R1";
        check(tag,
              {38'd0, ram_rd, rom_rd, ram_we_hi, ram_we_lo, via_cs, via_we, fdc_cs, fdc_we,
               scc_rd_cs, scc_wr_cs, cpu_rdata},
              {38'd0, e_ramrd, e_romrd, e_whi, e_wlo, e_via, e_via & ~r, e_fdc, e_fdc & ~r,
               e_sr, e_sw, e_rd}, ad);
        if (e_ramrd) check("R1", 64'(ram_addr), 64'(ad[16:1]), ad);
        if (e_romrd) check("R1", 64'(rom_addr), 64'(ad[15:1]), ad);
        if (e_whi | e_wlo) check("R3", 64'(ram_wdata), 64'(wdata), ad);
        if (devsel) check(tag, 64'(dev_reg),
                          64'((e_sr | e_sw) ? {2'b00, ad[2:1]} : ad[12:9]), ad);
        if (devsel && !r) check(tag, 64'(dev_wdata), 64'(wdata[7:0]), ad);
        check("R4", 64'(slow_bus), 64'(per), ad);
        check("R11", 64'($countones({ram_rd, rom_rd, via_cs, fdc_cs, scc_rd_cs, scc_wr_cs}) <= 1), 64'd1, ad);
    endtask

    task automatic sweep(input logic ov);
        logic [15:0] lows [8] = '{16'h0000, 16'h1234, 16'hE1FE, 16'hE1FF,
                                  16'hE0FE, 16'hE3FE, 16'hFFF8, 16'hFFFE};
        for (int h = 0; h < 256; h++)
            for (int p = 0; p < 8; p++)
                for (int s = 0; s < 8; s++)
                    access({h[7:0], lows[p]}, s[2], s[1], s[0], ov);
        uds = 1'b0; lds = 1'b0;
    endtask

    task automatic load_overlay(input logic v, input logic ld);
        @(negedge clk); pa4 = v; pa_load = ld;
        @(posedge clk);
        @(negedge clk); pa_load = 1'b0; pa4 = ~v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: no pulse, overlay on (address 0 reads ROM).
        check("R10", 64'(slow_en), 64'd0, 24'h0);
        access(24'h000000, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R9", 64'(rom_rd), 64'd1, 24'h0);
        uds = 1'b0; lds = 1'b0;
        rst_n = 1'b1;
        // Divided enable after release.
        for (int k = 1; k <= 22; k++) begin
            @(posedge clk); @(negedge clk);
            check("R10", 64'(slow_en), 64'((k % PERIOD) == PERIOD - 1), 24'(k));
        end
        // Overlay on from reset.
        sweep(1'b1);
        // Clear overlay through the port bit.
        load_overlay(1'b0, 1'b1);
        access(24'h000000, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R9", 64'(ram_rd), 64'd1, 24'h0);
        sweep(1'b0);
        // Bit without load strobe is ignored.
        load_overlay(1'b1, 1'b0);
        access(24'h000002, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R9", 64'(ram_rd), 64'd1, 24'h2);
        // Set it again.
        load_overlay(1'b1, 1'b1);
        access(24'h000002, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R9", 64'(rom_rd), 64'd1, 24'h2);
        uds = 1'b0; lds = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R10 got=hang exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule